// File: doc/BRIEF.md
# SDRAM Software Command Issuer

This block lets boot software bring SDRAM devices through their power-up sequence one command at a time. A small register port holds a 3-bit operation mode and a 3-bit CAS latency setting. Writing the operation mode does not put anything on the SDRAM pins. It only decides what the next access to a DIMM turns into. That access is usually a dummy write, and it can become a NOP, a precharge of all banks, a load of the device mode register, or, in normal mode, an ordinary read or write.

Each DIMM has its own chip select. Every accepted access is acknowledged on the cycle after it is sampled. On that same cycle the resulting command appears on the chip selects, on RAS, CAS and WE, and on the row address lines. When the device mode register is loaded, the block builds the mode word from the row address of the dummy write. The burst length, burst type and write-burst fields are forced to fixed values, and the CAS latency field is taken from the configuration register. The block does not handle refresh, the address mapping of normal traffic, or the timing of data bursts.

Top module: `sdcmd_issuer`

## Requirements
- R1: While reset is held, and after it until the first access, every chip select (active low) is high, RAS, CAS and WE (active low) are high, the address is 0, the acknowledge is 0 and the read data is 0.
- R2: The operation mode resets to 2 (precharge-all), so the first write to a DIMM after reset issues a precharge-all command.
- R3: A register write (select 0 = operation mode, select 1 = CAS latency) issues no SDRAM command. The outputs stay idle on the following cycle, and a new value applies to accesses sampled from the next cycle on.
- R4: Operation mode 0 is normal mode. A read issues READ (RAS=1, CAS=0, WE=1) and a write issues WRITE (RAS=1, CAS=0, WE=0), with the row address passed through to the address lines. For a read, the data bus value sampled with the access is returned with the acknowledge.
- R5: Operation mode 1 is NOP mode, and modes 4 to 7 behave the same way. A write asserts the target chip select with RAS, CAS and WE all high and the address at 0.
- R6: Operation mode 2 is precharge-all mode. A write issues RAS=0, CAS=1, WE=0 to the target with address bit 10 high and every other address bit 0.
- R7: Operation mode 3 is mode-register-load mode. A write issues RAS=0, CAS=0, WE=0 with the address equal to the write's row address, except that bits [2:0]=001 (burst of 2), bit 3=0 (sequential), bits [6:4]=the CAS latency setting and bit 9=0 (writes burst at the programmed length).
- R8: In every mode other than 0, a read is acknowledged with zero data and asserts no chip select.
- R9: A command asserts only the chip select of the target DIMM, and only for a single cycle. Every accepted access is acknowledged exactly one cycle after it is sampled, and there is no acknowledge otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 = operation mode, 1 = CAS latency |
| regWrData | input | 3 | Register write value |
| accValid | input | 1 | Access to a DIMM in this cycle |
| accWrite | input | 1 | 1 = write (dummy write), 0 = read |
| accDimm | input | DIMM_W | Target DIMM index |
| accRowAddr | input | ROW_W | Row address of the access |
| sdRdData | input | DATA_W | Data bus value sampled with a read |
| accAck | output | 1 | Access acknowledge |
| accRdData | output | DATA_W | Read data returned with the acknowledge |
| csN | output | NUM_DIMM | Per-DIMM chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| sdAddr | output | ROW_W | SDRAM address lines |

## Verification
The block has a single register stage. An access sampled at one rising edge shows its command, acknowledge and read data on the outputs for exactly the cycle after that edge. A register write sampled at an edge first affects an access sampled at the next edge. The bench drives every input at the falling edge and compares all outputs at the following falling edge, half a cycle after the register update. It also checks one cycle later that the chip selects and the acknowledge have dropped again. Directed cases cover reset, the first command after reset and each mode including a reserved one. Seeded random sequences then mix register writes with reads and writes to random DIMMs.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam logic [2:0] OP_NORMAL    = 3'd0;
  localparam logic [2:0] OP_NOP       = 3'd1;
  localparam logic [2:0] OP_PRECHARGE = 3'd2;
  localparam logic [2:0] OP_LOADMODE  = 3'd3;

  // fixed mode word fields
  localparam logic [2:0] BURST_LEN_2  = 3'b001;
  localparam logic       BURST_SEQ    = 1'b0;
  localparam logic       WBURST_PROG  = 1'b0;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_NOP   = 3'd1,
    CMD_PRE   = 3'd2,
    CMD_MRS   = 3'd3,
    CMD_READ  = 3'd4,
    CMD_WRITE = 3'd5
  } cmdKind_e;

  typedef struct packed {
    logic     fire;      // drive the target chip select
    logic     ack;       // acknowledge the access
    logic     passData;  // return sampled read data
    cmdKind_e kind;      // pin pattern to drive
  } strobes_t;

endpackage

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
#(
  parameter logic [2:0] CAS_RESET = 3'd2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regSel,
  input  logic [2:0] regWrData,
  input  logic       accValid,
  input  logic       accWrite,
  output strobes_t   strb,
  output logic [2:0] casLat
);

  logic [2:0] opModeQ;
  logic [2:0] casLatQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opModeQ <= OP_PRECHARGE;
      casLatQ <= CAS_RESET;
    end else if (regWrEn) begin
      if (regSel) casLatQ <= regWrData;
      else        opModeQ <= regWrData;
    end
  end

  assign casLat = casLatQ;

  always_comb begin
    strb          = '0;
    strb.kind     = CMD_NONE;
    if (accValid) begin
      strb.ack = 1'b1;
      unique case (opModeQ)
        OP_NORMAL: begin
          strb.fire     = 1'b1;
          strb.kind     = accWrite ? CMD_WRITE : CMD_READ;
          strb.passData = !accWrite;
        end
        OP_PRECHARGE: begin
          strb.fire = accWrite;
          strb.kind = accWrite ? CMD_PRE : CMD_NONE;
        end
        OP_LOADMODE: begin
          strb.fire = accWrite;
          strb.kind = accWrite ? CMD_MRS : CMD_NONE;
        end
        default: begin // NOP mode and reserved values
          strb.fire = accWrite;
          strb.kind = accWrite ? CMD_NOP : CMD_NONE;
        end
      endcase
    end
  end

endmodule

// File: rtl/sdcmd_datapath.sv
module sdcmd_datapath
  import sdcmd_pkg::*;
#(
  parameter int NUM_DIMM = 4,
  parameter int DIMM_W   = 2,
  parameter int ROW_W    = 13,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strb,
  input  logic [DIMM_W-1:0]   accDimm,
  input  logic [ROW_W-1:0]    accRowAddr,
  input  logic [DATA_W-1:0]   sdRdData,
  input  logic [2:0]          casLat,
  output logic                accAck,
  output logic [DATA_W-1:0]   accRdData,
  output logic [NUM_DIMM-1:0] csN,
  output logic                rasN,
  output logic                casN,
  output logic                weN,
  output logic [ROW_W-1:0]    sdAddr
);

  localparam int A10 = 10;

  logic [ROW_W-1:0] modeWord;
  logic [ROW_W-1:0] preAddr;
  logic [ROW_W-1:0] nextAddr;
  logic             nextRas, nextCas, nextWe;

  always_comb begin
    modeWord      = accRowAddr;
    modeWord[2:0] = BURST_LEN_2;
    modeWord[3]   = BURST_SEQ;
    modeWord[6:4] = casLat;
    modeWord[9]   = WBURST_PROG;
    preAddr       = '0;
    preAddr[A10]  = 1'b1;
  end

  always_comb begin
    nextRas  = 1'b1;
    nextCas  = 1'b1;
    nextWe   = 1'b1;
    nextAddr = '0;
    unique case (strb.kind)
      CMD_PRE:   begin nextRas = 1'b0; nextWe = 1'b0; nextAddr = preAddr; end
      CMD_MRS:   begin nextRas = 1'b0; nextCas = 1'b0; nextWe = 1'b0; nextAddr = modeWord; end
      CMD_READ:  begin nextCas = 1'b0; nextAddr = accRowAddr; end
      CMD_WRITE: begin nextCas = 1'b0; nextWe = 1'b0; nextAddr = accRowAddr; end
      default:   ; // idle or NOP: all strobes high, address zero
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasN      <= 1'b1;
      casN      <= 1'b1;
      weN       <= 1'b1;
      sdAddr    <= '0;
      accAck    <= 1'b0;
      accRdData <= '0;
    end else begin
      rasN      <= nextRas;
      casN      <= nextCas;
      weN       <= nextWe;
      sdAddr    <= nextAddr;
      accAck    <= strb.ack;
      accRdData <= strb.passData ? sdRdData : '0;
    end
  end

  for (genvar d = 0; d < NUM_DIMM; d++) begin : g_cs
    always_ff @(posedge clk) begin
      if (!rstN) csN[d] <= 1'b1;
      else       csN[d] <= !(strb.fire && (accDimm == DIMM_W'(d)));
    end
  end

endmodule

// File: rtl/sdcmd_issuer.sv
module sdcmd_issuer
  import sdcmd_pkg::*;
#(
  parameter int          NUM_DIMM  = 4,
  parameter int          ROW_W     = 13,
  parameter int          DATA_W    = 32,
  parameter logic [2:0]  CAS_RESET = 3'd2,
  localparam int         DIMM_W    = (NUM_DIMM > 1) ? $clog2(NUM_DIMM) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regSel,
  input  logic [2:0]          regWrData,
  input  logic                accValid,
  input  logic                accWrite,
  input  logic [DIMM_W-1:0]   accDimm,
  input  logic [ROW_W-1:0]    accRowAddr,
  input  logic [DATA_W-1:0]   sdRdData,
  output logic                accAck,
  output logic [DATA_W-1:0]   accRdData,
  output logic [NUM_DIMM-1:0] csN,
  output logic                rasN,
  output logic                casN,
  output logic                weN,
  output logic [ROW_W-1:0]    sdAddr
);

  strobes_t   strb;
  logic [2:0] casLat;

  sdcmd_ctrl #(.CAS_RESET(CAS_RESET)) ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .accValid(accValid), .accWrite(accWrite),
    .strb(strb), .casLat(casLat)
  );

  sdcmd_datapath #(
    .NUM_DIMM(NUM_DIMM), .DIMM_W(DIMM_W), .ROW_W(ROW_W), .DATA_W(DATA_W)
  ) dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .accDimm(accDimm),
    .accRowAddr(accRowAddr), .sdRdData(sdRdData), .casLat(casLat),
    .accAck(accAck), .accRdData(accRdData), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN), .sdAddr(sdAddr)
  );

endmodule

// File: rtl/sdcmd_issuer_chk.sv
module sdcmd_issuer_chk #(
  parameter int NUM_DIMM = 4,
  parameter int ROW_W    = 13,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                accValid,
  input logic                accAck,
  input logic [DATA_W-1:0]   accRdData,
  input logic [NUM_DIMM-1:0] csN,
  input logic                rasN,
  input logic                casN,
  input logic                weN,
  input logic [ROW_W-1:0]    sdAddr
);

  logic anyCs;
  assign anyCs = !(&csN);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN)); // R9

  AST_ACK_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> accAck); // R9

  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> (!accAck && &csN)); // R3

  AST_CMD_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    anyCs |-> accAck); // R9

  AST_PRE_A10_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (anyCs && !rasN && casN && !weN) |-> sdAddr[10]); // R6

  AST_MRS_FIXED_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    (anyCs && !rasN && !casN && !weN) |-> (sdAddr[3:0] == 4'b0001 && !sdAddr[9])); // R7

  AST_DATA_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (accRdData != '0) |-> (anyCs && rasN && !casN && weN)); // R8

  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    !anyCs |-> (rasN && casN && weN)); // R1

endmodule

bind sdcmd_issuer sdcmd_issuer_chk #(
  .NUM_DIMM(NUM_DIMM), .ROW_W(ROW_W), .DATA_W(DATA_W)
) chkInst (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accAck(accAck),
  .accRdData(accRdData), .csN(csN), .rasN(rasN), .casN(casN),
  .weN(weN), .sdAddr(sdAddr)
);

// File: tb/sdcmd_issuer_test.sv
module sdcmd_issuer_test;

  localparam int NUM_DIMM = 4;
  localparam int DIMM_W   = 2;
  localparam int ROW_W    = 13;
  localparam int DATA_W   = 32;
  localparam int OUT_W    = NUM_DIMM + 3 + ROW_W + 1 + DATA_W;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                regWrEn = 1'b0, regSel = 1'b0;
  logic [2:0]          regWrData = '0;
  logic                accValid = 1'b0, accWrite = 1'b0;
  logic [DIMM_W-1:0]   accDimm = '0;
  logic [ROW_W-1:0]    accRowAddr = '0;
  logic [DATA_W-1:0]   sdRdData = '0;
  logic                accAck;
  logic [DATA_W-1:0]   accRdData;
  logic [NUM_DIMM-1:0] csN;
  logic                rasN, casN, weN;
  logic [ROW_W-1:0]    sdAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [2:0] mdlMode = 3'd2;
  logic [2:0] mdlCas  = 3'd2;

  always #4 clk = ~clk; // 125 MHz

  sdcmd_issuer #(.NUM_DIMM(NUM_DIMM), .ROW_W(ROW_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .accValid(accValid), .accWrite(accWrite),
    .accDimm(accDimm), .accRowAddr(accRowAddr), .sdRdData(sdRdData),
    .accAck(accAck), .accRdData(accRdData), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .sdAddr(sdAddr)
  );

  function automatic logic [OUT_W-1:0] idleVec();
    return {{NUM_DIMM{1'b1}}, 3'b111, {ROW_W{1'b0}}, 1'b0, {DATA_W{1'b0}}};
  endfunction

  function automatic logic [OUT_W-1:0] expVec(logic [2:0] mode, logic [2:0] cas,
      logic wr, logic [DIMM_W-1:0] dimm, logic [ROW_W-1:0] row, logic [DATA_W-1:0] dq);
    logic [NUM_DIMM-1:0] cs;
    logic [2:0]          rcw;
    logic [ROW_W-1:0]    a;
    logic [DATA_W-1:0]   d;
    cs = ~(NUM_DIMM'(1) << dimm);
    d = '0;
    if (mode == 3'd0) begin
      rcw = wr ? 3'b100 : 3'b101;
      a   = row;
      if (!wr) d = dq;
    end else if (!wr) begin
      cs = '1; rcw = 3'b111; a = '0;
    end else if (mode == 3'd2) begin
      rcw = 3'b010; a = '0; a[10] = 1'b1;
    end else if (mode == 3'd3) begin
      rcw = 3'b000; a = row; a[2:0] = 3'b001; a[3] = 1'b0; a[6:4] = cas; a[9] = 1'b0;
    end else begin
      rcw = 3'b111; a = '0;
    end
    return {cs, rcw, a, 1'b1, d};
  endfunction

  function automatic string reqOf(logic [2:0] mode, logic wr);
    if (!wr && mode != 3'd0) return "R8";
    case (mode)
      3'd0: return "R4";
      3'd2: return "R6";
      3'd3: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic [OUT_W-1:0] exp);
    logic [OUT_W-1:0] act;
    act = {csN, rasN, casN, weN, sdAddr, accAck, accRdData};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic sel, logic [2:0] val);
    regWrEn = 1'b1; regSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
    check("R3", idleVec()); // no command from a register write
    if (sel) mdlCas = val; else mdlMode = val;
  endtask

  task automatic access(logic wr, logic [DIMM_W-1:0] dimm, logic [ROW_W-1:0] row,
                        logic [DATA_W-1:0] dq, logic checkIdle);
    accValid = 1'b1; accWrite = wr; accDimm = dimm; accRowAddr = row; sdRdData = dq;
    @(negedge clk);
    accValid = 1'b0; sdRdData = '0;
    check(reqOf(mdlMode, wr), expVec(mdlMode, mdlCas, wr, dimm, row, dq));
    if (checkIdle) begin
      @(negedge clk);
      check("R9", idleVec()); // chip select and ack last one cycle only
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1", idleVec());           // held in reset
    rstN = 1'b1;
    @(negedge clk);
    check("R1", idleVec());           // idle after reset
    // R2: first write after reset is precharge-all
    access(1'b1, 2'd1, 13'h1FFF, 32'h0, 1'b1);
    // R8: read in precharge mode
    access(1'b0, 2'd2, 13'h0123, 32'hDEAD_BEEF, 1'b1);
    regWrite(1'b0, 3'd1);
    access(1'b1, 2'd3, 13'h0AAA, 32'h0, 1'b1);   // R5 NOP
    regWrite(1'b1, 3'd3);
    regWrite(1'b0, 3'd3);
    access(1'b1, 2'd0, 13'h1FFF, 32'h0, 1'b1);   // R7 fixed fields override
    regWrite(1'b0, 3'd6);
    access(1'b1, 2'd2, 13'h1555, 32'h0, 1'b1);   // R5 reserved value
    regWrite(1'b0, 3'd0);
    access(1'b0, 2'd1, 13'h0F0F, 32'hCAFE_F00D, 1'b1); // R4 read
    access(1'b1, 2'd3, 13'h1234, 32'h0, 1'b1);   // R4 write
    // random mix, back-to-back accesses included
    for (int i = 0; i < 600; i++) begin
      int pick;
      pick = $urandom_range(0, 9);
      if (pick == 0)      regWrite(1'b0, 3'($urandom_range(0, 7)));
      else if (pick == 1) regWrite(1'b1, 3'($urandom_range(0, 7)));
      else access(1'($urandom_range(0, 1)), DIMM_W'($urandom_range(0, NUM_DIMM-1)),
                  ROW_W'($urandom), $urandom, 1'($urandom_range(0, 1)));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule